// File: doc/BRIEF.md
# Per-Step Divided Clock Sequencer

This block steps a scheduled datapath through its control steps, using one shared clock whose period changes from step to step. A small schedule table holds two things for each control step: a divide ratio and a mask of functional units that are active in that step. While the block runs, it counts base-clock cycles. It raises a one-cycle tick at the end of each divided period, so each control step lasts its own whole number of base cycles. The unit enables follow the current step's mask, so units that are idle in a step keep their input multiplexers closed.

The table is loaded through a write port before a sequence starts. A start pulse latches the number of steps to run and begins at step 0. The new step's ratio is taken only on a period boundary, so a period is never cut short. After the tick that ends the last step, the block raises done. It then stays quiet until the next start. Typical ratios are 1, 2 and 4 for adder-class steps and 2, 4 and 8 for multiplier-class steps, but any 4-bit value is accepted.

Top module: `stepdiv_ctrl`

## Requirements
- R1: After reset, tick_o, done_o, step_o and unit_en_o are all 0.
- R2: A start pulse latches num_steps_i and moves step_o to 0 on the next cycle. If num_steps_i is 0, done_o rises on the next cycle and no tick occurs.
- R3: While running, a step whose stored ratio field is N (1 to 15) lasts exactly N base cycles. tick_o is high in the last of those cycles. The first step counts from the first cycle after the start edge.
- R4: A stored ratio field of 0 behaves as ratio 1.
- R5: While running, unit_en_o equals the mask stored for the step shown on step_o; bit i enables unit i. Whenever the block is not running, unit_en_o is 0.
- R6: step_o increases by one in the cycle after each tick, except after the last step's tick. Otherwise it is unchanged, apart from a start pulse.
- R7: After the tick that ends step num_steps_i-1, done_o goes high and step_o holds num_steps_i-1. tick_o and unit_en_o stay 0, and done_o stays high, until the next start pulse.
- R8: A table write takes effect only when no sequence is running and start_i is low in that cycle. Otherwise the write is dropped.
- R9: A start pulse during a running sequence abandons it and restarts from step 0 with a fresh period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence at step 0 |
| num_steps_i | input | IDX_W+1 | Number of steps, sampled with start_i |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | IDX_W | Step entry to write |
| wr_ratio_i | input | RATIO_W | Divide ratio for the entry |
| wr_mask_i | input | NUM_UNITS | Unit activity mask for the entry |
| tick_o | output | 1 | Divided-clock enable, high in the last base cycle of a step |
| unit_en_o | output | NUM_UNITS | Enables of the active units |
| step_o | output | IDX_W | Current control step |
| done_o | output | 1 | Sequence finished |

## Verification
Two events can collide in one cycle. A start pulse can arrive in the same cycle as a period-ending tick. A table write can land in the cycle that starts a sequence, or while a sequence runs. The bench aborts a running sequence part-way through with a fresh start and then expects the full schedule again from step 0 with correct periods. It also issues writes during a run and in the start cycle itself. Each dropped write is judged by a later run, which must still show the old ratio and mask for that entry.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/stepdiv_table.sv
module stepdiv_table #(
    parameter int DEPTH     = 16,
    parameter int IDX_W     = 4,
    parameter int RATIO_W   = 4,
    parameter int NUM_UNITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_addr_i,
    input  logic [RATIO_W-1:0]   wr_ratio_i,
    input  logic [NUM_UNITS-1:0] wr_mask_i,
    input  logic [IDX_W-1:0]     ratio_addr_i,
    output logic [RATIO_W-1:0]   ratio_o,
    input  logic [IDX_W-1:0]     mask_addr_i,
    output logic [NUM_UNITS-1:0] mask_o
);
    logic [RATIO_W-1:0]   ratio_q [DEPTH];
    logic [NUM_UNITS-1:0] mask_q  [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic                 hit;
        logic [RATIO_W-1:0]   ratio_d;
        logic [NUM_UNITS-1:0] mask_d;

        always_comb begin
            hit     = wr_en_i && (wr_addr_i == IDX_W'(e));
            ratio_d = hit ? wr_ratio_i : ratio_q[e];
            mask_d  = hit ? wr_mask_i  : mask_q[e];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ratio_q[e] <= '0;
                mask_q[e]  <= '0;
            end else begin
                ratio_q[e] <= ratio_d;
                mask_q[e]  <= mask_d;
            end
        end
    end

    assign ratio_o = ratio_q[ratio_addr_i];
    assign mask_o  = mask_q[mask_addr_i];
endmodule

// File: rtl/stepdiv_period.sv
module stepdiv_period #(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               load_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
    } div_t;

    div_t div_d, div_q;

    assign tick_o = run_i && (div_q.cnt == div_q.ratio - 1'b1);

    always_comb begin
        div_d = div_q;
        if (load_i) begin
            div_d.cnt   = '0;
            div_d.ratio = ratio_i;
        end else if (tick_o) begin
            div_d.cnt = '0;
        end else if (run_i) begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q.cnt   <= '0;
            div_q.ratio <= RATIO_W'(1);
        end else begin
            div_q <= div_d;
        end
    end
endmodule

// File: rtl/stepdiv_ctrl.sv
module stepdiv_ctrl
    import stepdiv_pkg::*;
#(
    parameter  int STEPS_MAX = 16,
    parameter  int RATIO_W   = 4,
    parameter  int NUM_UNITS = 4,
    localparam int IDX_W     = $clog2(STEPS_MAX),
    localparam int CNT_W     = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CNT_W-1:0]     num_steps_i,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_addr_i,
    input  logic [RATIO_W-1:0]   wr_ratio_i,
    input  logic [NUM_UNITS-1:0] wr_mask_i,
    output logic                 tick_o,
    output logic [NUM_UNITS-1:0] unit_en_o,
    output logic [IDX_W-1:0]     step_o,
    output logic                 done_o
);
    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   step;
        logic [CNT_W-1:0]   len;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                 wr_ok;
    logic [IDX_W-1:0]     rd_addr;
    logic [RATIO_W-1:0]   ratio_raw;
    logic [RATIO_W-1:0]   ratio_eff;
    logic [NUM_UNITS-1:0] mask_cur;
    logic                 div_tick;
    logic                 div_load;
    logic                 is_last;
    logic                 running;

    assign running = (seq_q.phase == PH_RUN);
    assign wr_ok   = wr_en_i && !running && !start_i;
    assign rd_addr = start_i ? '0 : seq_q.step + 1'b1;

    stepdiv_table #(
        .DEPTH     (STEPS_MAX),
        .IDX_W     (IDX_W),
        .RATIO_W   (RATIO_W),
        .NUM_UNITS (NUM_UNITS)
    ) table_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_ok),
        .wr_addr_i    (wr_addr_i),
        .wr_ratio_i   (wr_ratio_i),
        .wr_mask_i    (wr_mask_i),
        .ratio_addr_i (rd_addr),
        .ratio_o      (ratio_raw),
        .mask_addr_i  (seq_q.step),
        .mask_o       (mask_cur)
    );

    assign ratio_eff = (ratio_raw == '0) ? RATIO_W'(1) : ratio_raw;

    stepdiv_period #(
        .RATIO_W (RATIO_W)
    ) period_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (running),
        .load_i  (div_load),
        .ratio_i (ratio_eff),
        .tick_o  (div_tick)
    );

    always_comb begin
        seq_d    = seq_q;
        div_load = 1'b0;
        is_last  = ({1'b0, seq_q.step} == seq_q.len - 1'b1);
        if (start_i) begin
            seq_d.step = '0;
            seq_d.len  = num_steps_i;
            if (num_steps_i == '0) begin
                seq_d.phase = PH_DONE;
            end else begin
                seq_d.phase = PH_RUN;
                div_load    = 1'b1;
            end
        end else if (running && div_tick) begin
            if (is_last) begin
                seq_d.phase = PH_DONE;
            end else begin
                seq_d.step = seq_q.step + 1'b1;
                div_load   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_IDLE;
            seq_q.step  <= '0;
            seq_q.len   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign tick_o    = div_tick;
    assign unit_en_o = running ? mask_cur : '0;
    assign step_o    = seq_q.step;
    assign done_o    = (seq_q.phase == PH_DONE);
endmodule

// File: rtl/stepdiv_ctrl_chk.sv
module stepdiv_ctrl_chk #(
    parameter int IDX_W     = 4,
    parameter int RATIO_W   = 4,
    parameter int NUM_UNITS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 tick_o,
    input logic [NUM_UNITS-1:0] unit_en_o,
    input logic [IDX_W-1:0]     step_o,
    input logic                 done_o
);
    localparam int GAP_W   = RATIO_W + 1;
    localparam int GAP_MAX = (1 << RATIO_W) - 1;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (start_i || tick_o) begin
            gap_q <= '0;
        end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !tick_o && !done_o && unit_en_o == '0); // R1
    AST_START_STEP0: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> step_o == '0); // R2
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tick_o |-> gap_q < GAP_W'(GAP_MAX)); // R3
    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!start_i && !tick_o) |=> $stable(step_o)); // R6
    AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (!start_i && tick_o) |=> (step_o == $past(step_o) + 1'b1) || done_o); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !tick_o && unit_en_o == '0); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !start_i) |=> done_o); // R7
endmodule

bind stepdiv_ctrl stepdiv_ctrl_chk #(
    .IDX_W     (IDX_W),
    .RATIO_W   (RATIO_W),
    .NUM_UNITS (NUM_UNITS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .tick_o    (tick_o),
    .unit_en_o (unit_en_o),
    .step_o    (step_o),
    .done_o    (done_o)
);

// File: tb/stepdiv_ctrl_tb_top.sv
`timescale 1ns/1ps
module stepdiv_ctrl_tb_top;
    localparam int STEPS = 16;
    localparam int RW    = 4;
    localparam int NU    = 4;
    localparam int IW    = $clog2(STEPS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW:0]   num = '0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_addr = '0;
    logic [RW-1:0] wr_ratio = '0;
    logic [NU-1:0] wr_mask = '0;
    logic          tick;
    logic [NU-1:0] unit_en;
    logic [IW-1:0] step;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [RW-1:0] m_ratio [STEPS];
    logic [NU-1:0] m_mask  [STEPS];

    always #2 clk = ~clk;

    stepdiv_ctrl #(.STEPS_MAX(STEPS), .RATIO_W(RW), .NUM_UNITS(NU)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .num_steps_i(num),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_ratio_i(wr_ratio), .wr_mask_i(wr_mask),
        .tick_o(tick), .unit_en_o(unit_en), .step_o(step), .done_o(done)
    );

    function automatic int eff(input logic [RW-1:0] r);
        return (r == 0) ? 1 : int'(r);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_entry(input int a, input int r, input int m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = IW'(a); wr_ratio = RW'(r); wr_mask = NU'(m);
        @(negedge clk);
        wr_en = 1'b0;
        m_ratio[a] = RW'(r);
        m_mask[a]  = NU'(m);
    endtask

    // abort_after > 0: leave after that many run cycles (for restart test)
    // poke: attempt a table write during the run (R8), start_wr: write in start cycle (R8)
    task automatic run_seq(input int len, input int abort_after, input bit poke, input bit start_wr);
        int s = 0;
        int k = 0;
        int cyc = 0;
        int r;
        @(negedge clk);
        start = 1'b1; num = (IW+1)'(len);
        if (start_wr) begin
            wr_en = 1'b1; wr_addr = '0; wr_ratio = ~m_ratio[0]; wr_mask = ~m_mask[0];
        end
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        check(step == '0, "R2", int'(step), 0);
        while (s < len) begin
            if (abort_after > 0 && cyc == abort_after) begin
                wr_en = 1'b0;
                return;
            end
            r = eff(m_ratio[s]);
            check(tick == (k == r - 1), "R3", int'(tick), int'(k == r - 1));
            check(step == IW'(s), "R6", int'(step), s);
            check(unit_en == m_mask[s], "R5", int'(unit_en), int'(m_mask[s]));
            if (poke && cyc == 1) begin
                wr_en = 1'b1; wr_addr = IW'(s); wr_ratio = ~m_ratio[s]; wr_mask = ~m_mask[s];
            end else begin
                wr_en = 1'b0;
            end
            if (k == r - 1) begin
                k = 0; s++;
            end else begin
                k++;
            end
            cyc++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(done == 1'b1, "R7", int'(done), 1);
            check(tick == 1'b0, "R7", int'(tick), 0);
            check(unit_en == '0, "R7", int'(unit_en), 0);
            if (len > 0) check(step == IW'(len - 1), "R7", int'(step), len - 1);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < STEPS; i++) begin
            m_ratio[i] = '0; m_mask[i] = '0;
        end
        #1;
        check(tick == 1'b0 && done == 1'b0, "R1", int'({tick, done}), 0);
        check(step == '0 && unit_en == '0, "R1", int'({step, unit_en}), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tick == 1'b0 && done == 1'b0 && unit_en == '0, "R1", int'({tick, done, unit_en}), 0);

        // Directed schedule: ratio 0 in step 0 (R4), typical ratios elsewhere
        write_entry(0, 0, 4'b0001);
        write_entry(1, 1, 4'b0011);
        write_entry(2, 2, 4'b0100);
        write_entry(3, 4, 4'b1000);
        write_entry(4, 8, 4'b1010);
        write_entry(5, 15, 4'b1111);
        run_seq(6, 0, 0, 0);
        check(m_ratio[0] == '0, "R4", int'(m_ratio[0]), 0);

        // Zero-length sequence: done at once, no tick (R2)
        @(negedge clk);
        start = 1'b1; num = '0;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && tick == 1'b0, "R2", int'({done, tick}), 2);

        // Writes during a run and in the start cycle are dropped (R8)
        run_seq(6, 0, 1, 1);
        run_seq(6, 0, 0, 0);

        // Restart while running (R9)
        run_seq(6, 7, 0, 0);
        run_seq(6, 0, 0, 0);
        run_seq(6, 1, 0, 0);
        run_seq(6, 0, 0, 0);

        // Random schedules over the full table
        for (int rnd = 0; rnd < 8; rnd++) begin
            for (int e = 0; e < STEPS; e++)
                write_entry(e, int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
            run_seq(int'($urandom_range(1, STEPS)), 0, rnd[0], rnd[1]);
        end
        run_seq(STEPS, 0, 0, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule